// File: doc/BRIEF.md
# MDIO Management Slave with PHY Register File

This block is the device side of a two-wire management bus. It samples the management clock (MDC) and data line (MDIO), both already synchronous to the system clock, and counts every MDC transition. It decodes a clause-22 style frame: a run of ones, a start bit, a two-bit opcode, a five-bit PHY address, a five-bit register number and a two-bit turnaround. For a write, sixteen data bits follow and are stored in a 32-entry, 16-bit register file. For a read, the block takes the data line and shifts the selected word out, least-significant bit first.

Phase lengths are measured in clock transitions, so each phase lasts twice its bit count in edges. The block answers at one PHY address. Register 1 is a fixed link and capability status word. Any other PHY address reads as all ones and its writes are dropped. If the start bit is missing, a warning output is raised, but the frame is still decoded to the end.

Top module: `mdio_phy_slave`

## Requirements
- R1: After synchronous reset, mdio_oe, mdio_o and start_warn are 0 and every entry of the register file reads 0x0000.
- R2: A frame is recognised only after at least 64 MDC transitions (32 clock periods) since the previous frame or reset, followed by MDIO low on a rising MDC edge. A shorter run of ones produces no response.
- R3: On the rising edge after the frame-start low, MDIO is sampled as the start bit. start_warn becomes 1 if it is 0 and becomes 0 if it is 1. Decoding continues in both cases, and start_warn changes only on rising MDC edges.
- R4: Opcode (2 bits), PHY address (5 bits) and register number (5 bits) are shifted in MSB first on rising edges. For any opcode other than binary 10, 16 data bits are then sampled MSB first on rising edges and stored at the end to the register addressed by the 5-bit register number.
- R5: For opcode binary 10, the block sets mdio_oe on the rising edge that ends the two-bit turnaround. It drives the addressed word LSB first, changing mdio_o only on falling MDC edges, with bit i valid after the (i+1)-th falling edge of the data phase.
- R6: Register 1 at the block's PHY address always reads 0x782C, even after a write to it. Other registers return the last value written.
- R7: The block responds only at PHY address 1. A read at any other address returns 0xFFFF, and a write there leaves the register file unchanged.
- R8: mdio_oe falls on the rising edge that completes the 16th data bit. The decoder then needs a new full preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock level, synchronous to clk |
| mdio_i | input | 1 | Management data line level as seen at the pin |
| mdio_o | output | 1 | Read data bit driven by the slave |
| mdio_oe | output | 1 | Output enable for the data line |
| start_warn | output | 1 | Set when the last frame lacked its start bit |

## Verification
The rising MDC edge that ends a frame does two things in the same cycle: it completes the write commit and it releases the line and re-arms the preamble counter. The bench provokes this with back-to-back frames separated by only the minimum preamble, so each read follows a write at once. It judges the result by the value read back and by mdio_oe being low after every frame. A frame with a missing start bit is also followed immediately by a read, to show that the warning and the write both took effect together.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_START,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA
  } mdio_state_e;

  localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_edge_det.sv
module mdio_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  output logic rise_o,
  output logic fall_o
);

  logic mdc_q;

  always_ff @(posedge clk) begin
    if (rst) mdc_q <= 1'b0;
    else     mdc_q <= mdc_i;
  end

  assign rise_o = mdc_i & ~mdc_q;
  assign fall_o = ~mdc_i & mdc_q;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int PRE_BITS = 32,
  localparam int PRE_EDGES  = 2 * PRE_BITS,
  localparam int OP_EDGES   = 4,
  localparam int ADDR_EDGES = 2 * ADDR_W,
  localparam int TA_EDGES   = 4,
  localparam int DATA_EDGES = 2 * DATA_W,
  localparam int CNT_MAX    = (PRE_EDGES > DATA_EDGES) ? PRE_EDGES : DATA_EDGES,
  localparam int CNT_W      = $clog2(CNT_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              start_warn
);

  mdio_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nx;
  logic [1:0]        opc;
  logic [DATA_W-1:0] sh;
  logic              drive;

  // transition counter saturates so a long idle preamble cannot wrap
  assign cnt_nx  = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
  assign wr_data = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PRE;
      cnt        <= '0;
      opc        <= '0;
      phy_addr   <= '0;
      reg_addr   <= '0;
      sh         <= '0;
      drive      <= 1'b0;
      mdio_o     <= 1'b0;
      mdio_oe    <= 1'b0;
      start_warn <= 1'b0;
      wr_en      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise || fall) begin
        cnt <= cnt_nx;
        unique case (state)
          ST_PRE: begin
            if (rise && cnt_nx >= CNT_W'(PRE_EDGES) && !mdio_i) begin
              cnt   <= '0;
              state <= ST_START;
            end
          end
          ST_START: begin
            if (rise) begin
              start_warn <= ~mdio_i;
              cnt        <= '0;
              opc        <= '0;
              state      <= ST_OP;
            end
          end
          ST_OP: begin
            if (rise) begin
              opc <= {opc[0], mdio_i};
              if (cnt_nx == CNT_W'(OP_EDGES)) begin
                cnt   <= '0;
                state <= ST_PHY;
              end
            end
          end
          ST_PHY: begin
            if (rise) begin
              phy_addr <= {phy_addr[ADDR_W-2:0], mdio_i};
              if (cnt_nx == CNT_W'(ADDR_EDGES)) begin
                cnt   <= '0;
                state <= ST_REG;
              end
            end
          end
          ST_REG: begin
            if (rise) begin
              reg_addr <= {reg_addr[ADDR_W-2:0], mdio_i};
              if (cnt_nx == CNT_W'(ADDR_EDGES)) begin
                cnt   <= '0;
                state <= ST_TA;
              end
            end
          end
          ST_TA: begin
            if (rise && cnt_nx == CNT_W'(TA_EDGES)) begin
              cnt   <= '0;
              state <= ST_DATA;
              if (opc == OP_READ) begin
                drive   <= 1'b1;
                mdio_oe <= 1'b1;
                sh      <= rd_word;
                mdio_o  <= rd_word[0];
              end else begin
                sh <= '0;
              end
            end
          end
          ST_DATA: begin
            if (fall && drive) begin
              mdio_o <= sh[0];
              sh     <= sh >> 1;
            end
            if (rise) begin
              if (!drive) sh <= {sh[DATA_W-2:0], mdio_i};
              if (cnt_nx == CNT_W'(DATA_EDGES)) begin
                cnt     <= '0;
                state   <= ST_PRE;
                drive   <= 1'b0;
                mdio_oe <= 1'b0;
                wr_en   <= ~drive;
              end
            end
          end
          default: state <= ST_PRE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
  parameter int          DATA_W      = 16,
  parameter int          ADDR_W      = 5,
  parameter int          NREG        = 32,
  parameter int          PRE_BITS    = 32,
  parameter int          PHY_ADDR    = 1,
  parameter int          STATUS_REG  = 1,
  parameter logic [15:0] STATUS_WORD = 16'h782C
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdio_o,
  output logic mdio_oe,
  output logic start_warn
);

  localparam int AW = $clog2(NREG);

  logic              rise, fall;
  logic [ADDR_W-1:0] phy_addr, reg_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rf_rdata, rd_word;
  logic              hit;

  mdio_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .mdc_i  (mdc_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_fsm #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PRE_BITS (PRE_BITS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .fall       (fall),
    .mdio_i     (mdio_i),
    .rd_word    (rd_word),
    .phy_addr   (phy_addr),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .start_warn (start_warn)
  );

  assign hit = (phy_addr == ADDR_W'(PHY_ADDR));

  mdio_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en & hit),
    .waddr (reg_addr[AW-1:0]),
    .wdata (wr_data),
    .raddr (reg_addr[AW-1:0]),
    .rdata (rf_rdata)
  );

  always_comb begin
    if (!hit)                                rd_word = '1;
    else if (reg_addr == ADDR_W'(STATUS_REG)) rd_word = DATA_W'(STATUS_WORD);
    else                                     rd_word = rf_rdata;
  end

endmodule

// File: rtl/mdio_phy_slave_chk.sv
module mdio_phy_slave_chk #(
  parameter int PRE_BITS = 32
) (
  input logic clk,
  input logic rst,
  input logic mdc_i,
  input logic mdio_o,
  input logic mdio_oe,
  input logic start_warn
);

  localparam int MIN_EDGES = 2 * PRE_BITS + 30;

  logic       mdc_d;
  logic [7:0] edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d <= mdc_i;
      edges <= '0;
    end else begin
      mdc_d <= mdc_i;
      if (mdc_i != mdc_d && edges != 8'hFF) edges <= edges + 8'd1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mdio_oe && !start_warn && !mdio_o));

  assert_preamble_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> ($past(edges) >= 8'(MIN_EDGES)));

  assert_warn_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(start_warn) |-> $past(mdc_i && !mdc_d));

  assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $past(!mdc_i && mdc_d));

  assert_oe_take_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $past(mdc_i && !mdc_d));

  assert_oe_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> $past(mdc_i && !mdc_d));

endmodule

bind mdio_phy_slave mdio_phy_slave_chk #(.PRE_BITS(PRE_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mdc_i      (mdc_i),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .start_warn (start_warn)
);

// File: tb/test_mdio_phy_slave.sv
`timescale 1ns/1ps
module test_mdio_phy_slave;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdc = 1'b0;
  logic mdio_in = 1'b1;
  logic mdio_o, mdio_oe, start_warn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] model [32];

  always #2 clk = ~clk;

  mdio_phy_slave i_mdio_phy_slave (
    .clk        (clk),
    .rst        (rst),
    .mdc_i      (mdc),
    .mdio_i     (mdio_in),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .start_warn (start_warn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half(input logic m, input logic d);
    mdc     = m;
    mdio_in = d;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    half(1'b0, b);
    half(1'b1, b);
  endtask

  function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] rg);
    if (phy != 5'd1)      return 16'hFFFF;
    else if (rg == 5'd1)  return 16'h782C;
    else                  return model[rg];
  endfunction

  task automatic frame(input int pre, input logic start_b, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rd,
                       output bit oe_all, output bit oe_any);
    rd = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(start_b);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(rg[i]);
    send_bit(1'b1);
    send_bit(1'b1);
    if (op == 2'b10) begin
      for (int i = 0; i < 16; i++) begin
        half(1'b0, 1'b1);
        rd[i] = mdio_o;
        oe_all &= mdio_oe;
        oe_any |= mdio_oe;
        half(1'b1, 1'b1);
      end
    end else begin
      for (int i = 15; i >= 0; i--) begin
        send_bit(wd[i]);
        oe_any |= mdio_oe;
      end
      if (phy == 5'd1) model[rg] = wd;
    end
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input string req);
    logic [15:0] rd;
    bit oa, on;
    logic [15:0] e;
    e = exp_read(phy, rg);
    frame(32, 1'b1, 2'b10, phy, rg, 16'h0, rd, oa, on);
    check(rd == e, req, 32'(rd), 32'(e));
    check(oa, "R5 oe held in data phase", 32'(oa), 32'd1);
    check(!mdio_oe, "R8 oe released", 32'(mdio_oe), 32'd0);
  endtask

  task automatic do_write(input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] wd);
    logic [15:0] rd;
    bit oa, on;
    frame(32, 1'b1, op, phy, rg, wd, rd, oa, on);
    check(!on, "R4 no drive during write", 32'(on), 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mdc = 1'b0;
    mdio_in = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
  endtask

  initial begin
    logic [15:0] rd;
    bit oa, on;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    check(!mdio_oe && !mdio_o && !start_warn, "R1 reset outputs",
          {29'd0, mdio_oe, mdio_o, start_warn}, 32'd0);

    // R2 short preamble: no response
    frame(20, 1'b1, 2'b10, 5'd1, 5'b11111, 16'h0, rd, oa, on);
    check(!on, "R2 short preamble ignored", 32'(on), 32'd0);
    do_reset();

    // R1 register file cleared
    do_read(5'd1, 5'd0, "R1 reg0 after reset");
    do_read(5'd1, 5'd31, "R1 reg31 after reset");

    // R4 write then read back, boundary registers
    do_write(2'b01, 5'd1, 5'd0, 16'hA5C3);
    do_read(5'd1, 5'd0, "R4 reg0 readback");
    do_write(2'b01, 5'd1, 5'd31, 16'h8001);
    do_read(5'd1, 5'd31, "R4 reg31 readback");
    do_write(2'b11, 5'd1, 5'd7, 16'h1234);
    do_read(5'd1, 5'd7, "R4 opcode 11 also writes");

    // R6 status register fixed
    do_read(5'd1, 5'd1, "R6 status word");
    do_write(2'b01, 5'd1, 5'd1, 16'h0000);
    do_read(5'd1, 5'd1, "R6 status after write");

    // R7 foreign address
    do_read(5'd2, 5'd0, "R7 foreign read all ones");
    do_write(2'b01, 5'd3, 5'd0, 16'h0F0F);
    do_read(5'd1, 5'd0, "R7 foreign write ignored");

    // R3 missing start bit: warning, frame still decoded
    frame(32, 1'b0, 2'b01, 5'd1, 5'd9, 16'hBEEF, rd, oa, on);
    check(start_warn, "R3 warning on missing start", 32'(start_warn), 32'd1);
    do_read(5'd1, 5'd9, "R3 frame decoded despite warning");
    check(!start_warn, "R3 warning cleared by good start", 32'(start_warn), 32'd0);

    // R8 long preamble after frame still works
    frame(40, 1'b1, 2'b10, 5'd1, 5'd0, 16'h0, rd, oa, on);
    check(rd == model[0], "R8 long preamble read", 32'(rd), 32'(model[0]));

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [4:0] phy, rg;
      logic [15:0] wd;
      int sel;
      phy = ($urandom % 2 == 0) ? 5'd1 : 5'($urandom);
      rg  = 5'($urandom);
      wd  = 16'($urandom);
      sel = $urandom % 8;
      if (sel < 4)       do_read(phy, rg, "R5 random read");
      else if (sel < 7)  do_write(2'b01, phy, rg, wd);
      else               do_write(2'b00, phy, rg, wd);
    end
    for (int r = 0; r < 32; r += 5) do_read(5'd1, 5'(r), "R4 final sweep");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule